// File: doc/BRIEF.md
# System Exception Control-State Register Block

This block holds the software-visible control and status words that sit beside an interrupt priority arbiter. Software reads them to see which exception is running, which one is waiting, and whether the core system exceptions are pending or active. Software writes them to pend or un-pend exceptions, to raise an external interrupt by number, to move the vector table base, to enable the three configurable fault handlers, and to request a reset or an active-state clear behind a 16-bit key. The arbiter lies outside the block. It supplies per-vector pending and active state plus the current active and top-pending vector numbers. It receives one-cycle set-pending and clear-pending pulses, the fault enables and the reset requests.

Vector numbering follows the usual scheme. Vectors 0 to 15 are system exceptions (non-maskable 2, memory fault 4, bus fault 5, usage fault 6, supervisor call 11, debug 12, pendable service 14, tick 15). External interrupt n is vector 16+n. There are `NUM_IRQ` external interrupts, 64 by default.

Access uses a simple request port and a three-state sequencer. ST_IDLE accepts a request while `bus_ready` is high. A read moves to ST_READ_RSP, where `rd_valid` and `rd_data` are presented. A write moves to ST_WRITE_DONE, where that write's pulses are presented. Both states return to ST_IDLE unconditionally, so every access takes two cycles.

Top module: `sysctl_regs`

## Requirements
- R1: After reset `bus_ready` is 1 and every other output is 0. A request accepted in ST_IDLE drops `bus_ready` for exactly the next cycle. A read presents `rd_valid`=1 with its data only in that next cycle.
- R2: Reading offset 0xD04 gives bits [8:0] = `act_vec` when `act_valid` is 1, else 0. Bit 11 is 1 when `act_valid` is 0 or `act_nested` is 0.
- R3: At 0xD04, bits [20:12] = `top_pend_vec` when `top_pend_valid` is 1, else 0. Bit 22 is 1 when any `exc_pending` bit at vector 16 or above is set.
- R4: At 0xD04, bits 26, 28 and 31 read the pending state of vectors 15, 14 and 2. Every other bit reads 0.
- R5: A write to 0xD04 pulses `set_pend[2]` on bit 31, `set_pend[14]` on bit 28 and `set_pend[15]` on bit 26. Bit 27 pulses `clr_pend[14]` and bit 25 pulses `clr_pend[15]`, but only when the matching set bit (28 or 26) is 0, so set wins.
- R6: Reading 0xD24 gives active state in bits 0,1,3,7,8,10,11 for vectors 4,5,6,11,12,14,15. It gives pending state in bits 12,13,14,15 for vectors 6,4,5,11.
- R7: Bits 16,17,18 of a write to 0xD24 are stored as `fault_en[0]` (memory), `[1]` (bus) and `[2]` (usage), and read back in the same bits. Other written bits have no effect.
- R8: A write to 0xD08 stores the data with bits [6:0] forced to 0 onto `vec_base`. Reading 0xD08 returns `vec_base`.
- R9: A write to 0xD0C with bits [31:16] = 0x05FA pulses `sys_reset_req` if bit 0 or bit 2 is 1, and pulses `clr_active_req` if bit 1 is 1. With any other key it pulses nothing. Reading 0xD0C returns 0x0FA05000.
- R10: A write to 0xF00 pulses `set_pend[16+n]` where n = data bits [8:0], only when n < `NUM_IRQ`. Otherwise it pulses nothing.
- R11: Any other offset reads 0. A write to it produces no pulse and changes neither `fault_en` nor `vec_base`.
- R12: Each set, clear and request pulse is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle when high |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| exc_pending | input | NVEC | Pending state per vector |
| exc_active | input | NVEC | Active state per vector |
| act_vec | input | 9 | Running vector number |
| act_valid | input | 1 | A handler is running |
| act_nested | input | 1 | Running handler preempted another |
| top_pend_vec | input | 9 | Highest-priority pending vector |
| top_pend_valid | input | 1 | Something is pending |
| set_pend | output | NVEC | One-cycle set-pending pulses |
| clr_pend | output | NVEC | One-cycle clear-pending pulses |
| fault_en | output | 3 | Memory, bus, usage fault enables |
| vec_base | output | 32 | Vector table base |
| clr_active_req | output | 1 | Keyed active-clear request pulse |
| sys_reset_req | output | 1 | Keyed reset request pulse |

## Verification
The control word's write side is swept over all 32 combinations of its five command bits. This separates set-wins resolution from independent set and clear handling, and shows that no pulse outlives its cycle. The read side is tried with a one-hot pending walk and a one-hot active walk across every vector. Each walk shows which status bit each vector reaches and that vectors from 16 upward alone drive the any-external flag. A full 512-value walk of the active and top-pending numbers, with the valid and nested flags toggling, covers the zero-substitution and the no-preemption bit. The software trigger is swept over all 512 numbers to find the exact range edge. The keyed word is tried with the right key and a wrong key, each with all eight low-bit patterns.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int VEC_W    = 9;
    localparam int EXT_BASE = 16;

    localparam int X_NMI   = 2;
    localparam int X_MEM   = 4;
    localparam int X_BUS   = 5;
    localparam int X_USAGE = 6;
    localparam int X_SVC   = 11;
    localparam int X_DEBUG = 12;
    localparam int X_PSV   = 14;
    localparam int X_TICK  = 15;

    localparam logic [11:0] A_CTRL   = 12'hD04;
    localparam logic [11:0] A_VBASE  = 12'hD08;
    localparam logic [11:0] A_RSTCTL = 12'hD0C;
    localparam logic [11:0] A_HND    = 12'hD24;
    localparam logic [11:0] A_TRIG   = 12'hF00;

    localparam logic [15:0] RST_KEY   = 16'h05FA;
    localparam logic [31:0] RSTCTL_RD = 32'h0FA0_5000;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_READ_RSP   = 2'd1,
        ST_WRITE_DONE = 2'd2
    } acc_state_t;
endpackage

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
#(
    parameter int NVEC = 80
) (
    input  logic [11:0]      addr,
    input  logic [NVEC-1:0]  exc_pending,
    input  logic [NVEC-1:0]  exc_active,
    input  logic [VEC_W-1:0] act_vec,
    input  logic             act_valid,
    input  logic             act_nested,
    input  logic [VEC_W-1:0] top_pend_vec,
    input  logic             top_pend_valid,
    input  logic [2:0]       fault_en,
    input  logic [31:0]      vec_base,
    output logic [31:0]      rdata
);
    logic [31:0] ctrl_word;
    logic [31:0] hnd_word;
    logic        ext_any;
    logic        unused_state;

    assign ext_any      = |exc_pending[NVEC-1:EXT_BASE];
    assign unused_state = ^{exc_pending, exc_active};

    always_comb begin
        ctrl_word        = '0;
        ctrl_word[8:0]   = act_valid ? act_vec : '0;
        ctrl_word[11]    = !act_valid || !act_nested;
        ctrl_word[20:12] = top_pend_valid ? top_pend_vec : '0;
        ctrl_word[22]    = ext_any;
        ctrl_word[26]    = exc_pending[X_TICK];
        ctrl_word[28]    = exc_pending[X_PSV];
        ctrl_word[31]    = exc_pending[X_NMI];
    end

    always_comb begin
        hnd_word        = '0;
        hnd_word[0]     = exc_active[X_MEM];
        hnd_word[1]     = exc_active[X_BUS];
        hnd_word[3]     = exc_active[X_USAGE];
        hnd_word[7]     = exc_active[X_SVC];
        hnd_word[8]     = exc_active[X_DEBUG];
        hnd_word[10]    = exc_active[X_PSV];
        hnd_word[11]    = exc_active[X_TICK];
        hnd_word[12]    = exc_pending[X_USAGE];
        hnd_word[13]    = exc_pending[X_MEM];
        hnd_word[14]    = exc_pending[X_BUS];
        hnd_word[15]    = exc_pending[X_SVC];
        hnd_word[18:16] = fault_en;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = ctrl_word;
            A_VBASE:  rdata = vec_base;
            A_RSTCTL: rdata = RSTCTL_RD;
            A_HND:    rdata = hnd_word;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysctl_write_decode.sv
module sysctl_write_decode
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NVEC    = 80
) (
    input  logic            wr,
    input  logic [11:0]     addr,
    input  logic [31:0]     wdata,
    output logic [NVEC-1:0] set_nx,
    output logic [NVEC-1:0] clr_nx,
    output logic            sys_rst_nx,
    output logic            clr_act_nx
);
    logic             ctrl_wr;
    logic             trig_wr;
    logic             key_ok;
    logic [VEC_W-1:0] trig_id;
    logic             trig_hit;
    logic             unused_wd;

    assign ctrl_wr   = wr && (addr == A_CTRL);
    assign trig_wr   = wr && (addr == A_TRIG);
    assign key_ok    = wr && (addr == A_RSTCTL) && (wdata[31:16] == RST_KEY);
    assign trig_id   = wdata[VEC_W-1:0];
    assign trig_hit  = trig_wr && (32'(trig_id) < 32'(NUM_IRQ));
    assign unused_wd = ^wdata;

    assign sys_rst_nx = key_ok && (wdata[0] || wdata[2]);
    assign clr_act_nx = key_ok && wdata[1];

    genvar gi;
    generate
        for (gi = 0; gi < NVEC; gi++) begin : g_vec
            if (gi == X_NMI) begin : g_nmi
                assign set_nx[gi] = ctrl_wr && wdata[31];
                assign clr_nx[gi] = 1'b0;
            end else if (gi == X_PSV) begin : g_psv
                assign set_nx[gi] = ctrl_wr && wdata[28];
                assign clr_nx[gi] = ctrl_wr && !wdata[28] && wdata[27];
            end else if (gi == X_TICK) begin : g_tick
                assign set_nx[gi] = ctrl_wr && wdata[26];
                assign clr_nx[gi] = ctrl_wr && !wdata[26] && wdata[25];
            end else if (gi >= EXT_BASE) begin : g_ext
                assign set_nx[gi] = trig_hit && (trig_id == VEC_W'(gi - EXT_BASE));
                assign clr_nx[gi] = 1'b0;
            end else begin : g_none
                assign set_nx[gi] = 1'b0;
                assign clr_nx[gi] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/sysctl_cfg_regs.sv
module sysctl_cfg_regs
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [2:0]  fault_en,
    output logic [31:0] vec_base
);
    logic unused_wd;
    assign unused_wd = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_en <= '0;
            vec_base <= '0;
        end else if (wr) begin
            if (addr == A_HND)   fault_en <= wdata[18:16];
            if (addr == A_VBASE) vec_base <= {wdata[31:7], 7'b0};
        end
    end

    // R8
    vbase_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_VBASE) |=> (vec_base == {$past(wdata[31:7]), 7'b0}));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_HND) |=> $stable(fault_en));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NVEC    = EXT_BASE + NUM_IRQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ready,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    input  logic [NVEC-1:0]  exc_pending,
    input  logic [NVEC-1:0]  exc_active,
    input  logic [VEC_W-1:0] act_vec,
    input  logic             act_valid,
    input  logic             act_nested,
    input  logic [VEC_W-1:0] top_pend_vec,
    input  logic             top_pend_valid,
    output logic [NVEC-1:0]  set_pend,
    output logic [NVEC-1:0]  clr_pend,
    output logic [2:0]       fault_en,
    output logic [31:0]      vec_base,
    output logic             clr_active_req,
    output logic             sys_reset_req
);
    acc_state_t      state_q, state_nx;
    logic            accept;
    logic            wr_acc;
    logic            rd_acc;
    logic [31:0]     rd_mux;
    logic [NVEC-1:0] set_nx, clr_nx;
    logic            sys_rst_nx, clr_act_nx;

    assign bus_ready = (state_q == ST_IDLE);
    assign accept    = bus_req && bus_ready;
    assign wr_acc    = accept && bus_we;
    assign rd_acc    = accept && !bus_we;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept) state_nx = bus_we ? ST_WRITE_DONE : ST_READ_RSP;
            ST_READ_RSP:   state_nx = ST_IDLE;
            ST_WRITE_DONE: state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    sysctl_read_mux #(.NVEC(NVEC)) u_rmux (
        .addr(bus_addr), .exc_pending(exc_pending), .exc_active(exc_active),
        .act_vec(act_vec), .act_valid(act_valid), .act_nested(act_nested),
        .top_pend_vec(top_pend_vec), .top_pend_valid(top_pend_valid),
        .fault_en(fault_en), .vec_base(vec_base), .rdata(rd_mux)
    );

    sysctl_write_decode #(.NUM_IRQ(NUM_IRQ), .NVEC(NVEC)) u_wdec (
        .wr(wr_acc), .addr(bus_addr), .wdata(bus_wdata),
        .set_nx(set_nx), .clr_nx(clr_nx),
        .sys_rst_nx(sys_rst_nx), .clr_act_nx(clr_act_nx)
    );

    sysctl_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(wr_acc), .addr(bus_addr),
        .wdata(bus_wdata), .fault_en(fault_en), .vec_base(vec_base)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid       <= 1'b0;
            rd_data        <= '0;
            set_pend       <= '0;
            clr_pend       <= '0;
            sys_reset_req  <= 1'b0;
            clr_active_req <= 1'b0;
        end else begin
            rd_valid       <= rd_acc;
            rd_data        <= rd_acc ? rd_mux : '0;
            set_pend       <= set_nx;
            clr_pend       <= clr_nx;
            sys_reset_req  <= sys_rst_nx;
            clr_active_req <= clr_act_nx;
        end
    end

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> !bus_ready);

    // R1
    rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_req && bus_ready && !bus_we));

    // R5
    set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pend) |-> ((set_pend & clr_pend) == '0));

    // R12
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{set_pend, clr_pend, sys_reset_req, clr_active_req}) |=>
        !(|{set_pend, clr_pend, sys_reset_req, clr_active_req}));

    // R9
    key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_req || clr_active_req) |->
        $past(bus_addr == A_RSTCTL && bus_wdata[31:16] == RST_KEY && bus_we));
endmodule

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;
    localparam int NUM_IRQ = 64;
    localparam int NVEC    = 16 + NUM_IRQ;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_ready, rd_valid;
    logic [31:0]     rd_data;
    logic [NVEC-1:0] exc_pending = '0, exc_active = '0;
    logic [8:0]      act_vec = '0, top_pend_vec = '0;
    logic            act_valid = 1'b0, act_nested = 1'b0, top_pend_valid = 1'b0;
    logic [NVEC-1:0] set_pend, clr_pend;
    logic [2:0]      fault_en;
    logic [31:0]     vec_base;
    logic            clr_active_req, sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [NVEC-1:0] s_set, s_clr;
    logic            s_sys, s_cact;
    logic [31:0]     s_rd;
    logic            s_rv;

    always #2.5 clk = ~clk;

    sysctl_regs #(.NUM_IRQ(NUM_IRQ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .exc_pending(exc_pending),
        .exc_active(exc_active), .act_vec(act_vec), .act_valid(act_valid),
        .act_nested(act_nested), .top_pend_vec(top_pend_vec),
        .top_pend_valid(top_pend_valid), .set_pend(set_pend), .clr_pend(clr_pend),
        .fault_en(fault_en), .vec_base(vec_base), .clr_active_req(clr_active_req),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        s_set = set_pend; s_clr = clr_pend; s_sys = sys_reset_req; s_cact = clr_active_req;
    endtask

    task automatic do_rd(input logic [11:0] a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        s_rd = rd_data; s_rv = rd_valid;
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[8:0]   = act_valid ? act_vec : 9'd0;
        v[11]    = !act_valid || !act_nested;
        v[20:12] = top_pend_valid ? top_pend_vec : 9'd0;
        v[22]    = |exc_pending[NVEC-1:16];
        v[26]    = exc_pending[15];
        v[28]    = exc_pending[14];
        v[31]    = exc_pending[2];
        return v;
    endfunction

    function automatic logic [31:0] exp_hnd(input logic [2:0] fe);
        logic [31:0] v = '0;
        v[0] = exc_active[4];  v[1] = exc_active[5];  v[3] = exc_active[6];
        v[7] = exc_active[11]; v[8] = exc_active[12]; v[10] = exc_active[14];
        v[11] = exc_active[15];
        v[12] = exc_pending[6]; v[13] = exc_pending[4];
        v[14] = exc_pending[5]; v[15] = exc_pending[11];
        v[18:16] = fe;
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [NVEC-1:0] es, ec;
        logic [2:0]      fe_model;
        logic [31:0]     vb_model;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", 128'(bus_ready), 128'd1);
        check("R1 rd_valid", 128'(rd_valid), 128'd0);
        check("R1 pulses", 128'({set_pend, clr_pend, sys_reset_req, clr_active_req}), 128'd0);
        check("R1 cfg", 128'({fault_en, vec_base}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 handshake timing
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'hD0C;
        @(negedge clk);
        bus_req = 1'b0;
        check("R1 ready low after accept", 128'(bus_ready), 128'd0);
        check("R1 rd_valid", 128'(rd_valid), 128'd1);
        @(negedge clk);
        check("R1 rd_valid one cycle", 128'(rd_valid), 128'd0);
        check("R1 ready back", 128'(bus_ready), 128'd1);

        // R5 R12 control-word command sweep
        for (int v = 0; v < 32; v++) begin
            logic [31:0] d;
            d = '0;
            d[31] = v[4]; d[28] = v[3]; d[27] = v[2]; d[26] = v[1]; d[25] = v[0];
            es = '0; ec = '0;
            es[2]  = v[4];
            es[14] = v[3];
            ec[14] = !v[3] && v[2];
            es[15] = v[1];
            ec[15] = !v[1] && v[0];
            do_wr(12'hD04, d);
            check("R5 set", 128'(s_set), 128'(es));
            check("R5 clr", 128'(s_clr), 128'(ec));
            @(negedge clk);
            check("R12 pulse width", 128'({set_pend, clr_pend}), 128'd0);
        end

        // R3 R4 R6 pending walk
        fe_model = 3'd0;
        for (int i = 0; i < NVEC; i++) begin
            exc_pending = '0; exc_pending[i] = 1'b1;
            do_rd(12'hD04);
            check("R4 R3 ctrl read pending walk", 128'(s_rd), 128'(exp_ctrl()));
            do_rd(12'hD24);
            check("R6 hnd read pending walk", 128'(s_rd), 128'(exp_hnd(fe_model)));
        end
        exc_pending = '0;

        // R6 active walk
        for (int i = 0; i < NVEC; i++) begin
            exc_active = '0; exc_active[i] = 1'b1;
            do_rd(12'hD24);
            check("R6 hnd read active walk", 128'(s_rd), 128'(exp_hnd(fe_model)));
        end
        exc_active = '0;

        // R2 R3 vector number walk
        for (int a = 0; a < 512; a++) begin
            act_vec = 9'(a); act_valid = a[0] | a[3]; act_nested = a[1];
            top_pend_vec = 9'(511 - a); top_pend_valid = a[2];
            do_rd(12'hD04);
            check("R2 R3 vector fields", 128'(s_rd), 128'(exp_ctrl()));
        end
        act_valid = 1'b0; top_pend_valid = 1'b0;

        // R7 fault enables
        for (int f = 0; f < 8; f++) begin
            do_wr(12'hD24, 32'hFFF8_FFFF | (32'(f) << 16));
            fe_model = 3'(f);
            check("R7 fault_en", 128'(fault_en), 128'(fe_model));
            check("R7 no pulse", 128'({s_set, s_clr}), 128'd0);
            do_rd(12'hD24);
            check("R7 readback", 128'(s_rd), 128'(exp_hnd(fe_model)));
        end

        // R8 vector base
        vb_model = '0;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = 32'h1234_567F ^ (32'hA5A5_5A5A << k);
            do_wr(12'hD08, d);
            vb_model = d & 32'hFFFF_FF80;
            check("R8 vec_base", 128'(vec_base), 128'(vb_model));
            do_rd(12'hD08);
            check("R8 readback", 128'(s_rd), 128'(vb_model));
        end

        // R9 keyed reset word
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic [31:0] d;
                d = {(k == 0) ? 16'h05FA : 16'h05FB, 13'd0, 3'(b)};
                do_wr(12'hD0C, d);
                check("R9 sys reset", 128'(s_sys), 128'((k == 0) && (b[0] || b[2])));
                check("R9 clr active", 128'(s_cact), 128'((k == 0) && b[1]));
            end
        end
        do_rd(12'hD0C);
        check("R9 read const", 128'(s_rd), 128'(32'h0FA0_5000));

        // R10 software trigger sweep
        for (int n = 0; n < 512; n++) begin
            es = '0;
            if (n < NUM_IRQ) es[16 + n] = 1'b1;
            do_wr(12'hF00, 32'hFFFF_FE00 | 32'(n));
            check("R10 trigger", 128'(s_set), 128'(es));
            check("R10 no clear", 128'(s_clr), 128'd0);
        end

        // R11 unmapped offsets
        exc_pending = '1; exc_active = '1;
        for (int k = 0; k < 4; k++) begin
            logic [11:0] a;
            a = (k == 0) ? 12'h100 : (k == 1) ? 12'hD10 : (k == 2) ? 12'hD28 : 12'hF04;
            do_wr(a, 32'hFFFF_FFFF);
            check("R11 no pulse", 128'({s_set, s_clr, s_sys, s_cact}), 128'd0);
            check("R11 cfg unchanged", 128'({fault_en, vec_base}), 128'({fe_model, vb_model}));
            do_rd(a);
            check("R11 read zero", 128'(s_rd), 128'd0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule